// File: doc/BRIEF.md
# Single-Transaction MMIO Bus with Reply Multiplexer

This block is a narrow memory-mapped I/O bus that carries exactly one request at a time. A master-side sequencer takes requests from several initiators. It grants them in arrival order and broadcasts a 5-bit opcode, a 28-bit address and 64-bit write data to every device. It then runs a four-phase handshake. The request is held until a device answers with a completion code. The master then drops the opcode to idle, and the transaction closes only after the device's code falls back to ready. A new request can start only after that.

Each device drives its own 2-bit reply code and 64-bit read data. A reply multiplexer with no address decoding forwards whichever device is not showing ready. The devices are register-file models, each owning one 4 KiB page. A broadcast probe command makes every device answer at once, which exercises the collision flag. Addresses that no device claims end in an error after a fixed timeout.

Top module: `mmio_bus_top`

## Requirements
- R1: The opcode is op[4:3] class and op[2:0] size. Class 01 is load, 10 is store, 11 is swap and 00 is special. Size 010 is a 32-bit word, 011 is a 64-bit word and 111 is a tile. 00000 is idle, and 00001 is the broadcast probe.
- R2: The master keeps opcode, address and data unchanged while the reply code is ready or busy (10). It drives idle after a done (01) or error (11) code. It signals completion one cycle after it observes ready (00) again.
- R3: At most one request is on the bus. A new opcode appears only after the bus reply has returned to ready, and done_o is one-hot or zero.
- R4: Register semantics. The device on page 16+d (addr[27:12]) holds 8 words indexed by addr[5:3]. A 64-bit load returns the word. A 32-bit load returns the low half zero-extended. A 32-bit store replaces only the low half. A swap returns the old value under the same size rule and writes the new one.
- R5: A claimed request shows busy on the bus for 2 cycles, then done or error for 2 cycles. done_o rises 6 cycles after the opcode first appears.
- R6: The reply multiplexer forwards the code and data of a device not showing ready. resp_o reports the code that ended the transaction.
- R7: On the probe, every device answers. The lowest-numbered device wins, so the read data is 0, and collide_o is high while more than one device is not ready.
- R8: A request no device claims, whether an unmapped page or a special command other than the probe, completes with error and zero data. The opcode is held for 16 cycles, and done_o rises 17 cycles after it first appears.
- R9: A load, store or swap to a mapped page with a size other than 010 or 011 returns error with zero data and leaves the registers unchanged.
- R10: Initiators are granted first come, first served. Among requests that arrive in the same cycle, the lower index goes first.
- R11: After reset the bus opcode is idle, the bus code is ready, done_o is zero and collide_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_INIT | Per-initiator request, held until its done_o |
| op_i | input | 5*N_INIT | Per-initiator opcode |
| addr_i | input | 28*N_INIT | Per-initiator address |
| wdata_i | input | 64*N_INIT | Per-initiator write data |
| done_o | output | N_INIT | One-cycle completion pulse per initiator |
| rdata_o | output | 64 | Read data of the last completed request |
| resp_o | output | 2 | Final reply code of the last completed request |
| bus_op_o | output | 5 | Broadcast opcode |
| bus_addr_o | output | 28 | Broadcast address |
| bus_ok_o | output | 2 | Multiplexed reply code (00 ready, 01 done, 10 busy, 11 error) |
| collide_o | output | 1 | More than one device not ready |

## Verification
Take P as the cycle in which the opcode first appears, which is one cycle after the request is sampled. A claimed request shows busy in P+1 and P+2 and done or error in P+3 and P+4. The opcode returns to idle in P+4, and done_o, rdata_o and resp_o are due in P+6. An unclaimed request keeps the opcode through P+15 and completes in P+17. The bench schedules every transaction at these offsets in a behavioural queue model and compares opcode, reply code, collision flag and done vector at every falling edge, so any early or late result is reported in its own cycle.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  localparam int OP_W   = 5;
  localparam int ADDR_W = 28;
  localparam int DATA_W = 64;
  localparam int OK_W   = 2;
  localparam int OFF_W  = 12;
  localparam int PAGE_W = ADDR_W - OFF_W;

  typedef enum logic [1:0] {
    OK_READY = 2'b00,
    OK_DONE  = 2'b01,
    OK_HOLD  = 2'b10,
    OK_ERR   = 2'b11
  } ok_e;

  localparam logic [1:0] CLS_SPEC  = 2'b00;
  localparam logic [1:0] CLS_LOAD  = 2'b01;
  localparam logic [1:0] CLS_STORE = 2'b10;
  localparam logic [1:0] CLS_SWAP  = 2'b11;

  localparam logic [2:0] SZ_PROBE = 3'b001;
  localparam logic [2:0] SZ_DW    = 3'b010;
  localparam logic [2:0] SZ_QW    = 3'b011;
  localparam logic [2:0] SZ_TILE  = 3'b111;

  localparam logic [OP_W-1:0] OP_IDLE = '0;
endpackage

// File: rtl/mmio_arbiter.sv
module mmio_arbiter
  import mmio_pkg::*;
#(
  parameter int N_INIT = 2,
  parameter int AGE_W  = 8,
  localparam int IDX_W = (N_INIT > 1) ? $clog2(N_INIT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_INIT-1:0] elig_i,
  input  logic              take_i,
  output logic              win_valid_o,
  output logic [IDX_W-1:0]  win_idx_o
);
  logic [AGE_W-1:0] age_q [N_INIT];
  logic [AGE_W-1:0] best_age;

  // oldest waiting request wins, ties go to the lower index
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    best_age    = '0;
    for (int i = 0; i < N_INIT; i++) begin
      if (elig_i[i] && (!win_valid_o || age_q[i] > best_age)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(i);
        best_age    = age_q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_INIT; i++) age_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_INIT; i++) begin
        if (!elig_i[i] || (take_i && win_valid_o && win_idx_o == IDX_W'(i)))
          age_q[i] <= '0;
        else if (age_q[i] != '1)
          age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  AST_WIN_ELIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> elig_i[win_idx_o]); // R10
endmodule

// File: rtl/mmio_master.sv
module mmio_master
  import mmio_pkg::*;
#(
  parameter int N_INIT  = 2,
  parameter int TIMEOUT = 16,
  localparam int IDX_W  = (N_INIT > 1) ? $clog2(N_INIT) : 1,
  localparam int TCNT_W = $clog2(TIMEOUT + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     win_valid_i,
  input  logic [IDX_W-1:0]         win_idx_i,
  input  logic [N_INIT*OP_W-1:0]   op_i,
  input  logic [N_INIT*ADDR_W-1:0] addr_i,
  input  logic [N_INIT*DATA_W-1:0] wdata_i,
  input  logic [OK_W-1:0]          bus_ok_i,
  input  logic [DATA_W-1:0]        bus_rdata_i,
  output logic                     take_o,
  output logic                     busy_o,
  output logic [IDX_W-1:0]         cur_idx_o,
  output logic [OP_W-1:0]          bus_op_o,
  output logic [ADDR_W-1:0]        bus_addr_o,
  output logic [DATA_W-1:0]        bus_wdata_o,
  output logic [N_INIT-1:0]        done_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [OK_W-1:0]          resp_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_TEAR} st_e;

  st_e               st_q;
  logic [OP_W-1:0]   op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [IDX_W-1:0]  cur_q;
  logic [TCNT_W-1:0] tcnt_q;
  logic [N_INIT-1:0] done_q;
  logic [DATA_W-1:0] rdata_q;
  logic [OK_W-1:0]   resp_q;
  logic              replied;

  assign replied     = (bus_ok_i == OK_DONE) || (bus_ok_i == OK_ERR);
  assign take_o      = (st_q == ST_IDLE);
  assign busy_o      = (st_q != ST_IDLE);
  assign cur_idx_o   = cur_q;
  assign bus_op_o    = (st_q == ST_REQ) ? op_q : OP_IDLE;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
  assign resp_o      = resp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      cur_q   <= '0;
      tcnt_q  <= '0;
      done_q  <= '0;
      rdata_q <= '0;
      resp_q  <= OK_READY;
    end else begin
      done_q <= '0;
      unique case (st_q)
        ST_IDLE: if (win_valid_i) begin
          op_q    <= op_i[win_idx_i*OP_W +: OP_W];
          addr_q  <= addr_i[win_idx_i*ADDR_W +: ADDR_W];
          wdata_q <= wdata_i[win_idx_i*DATA_W +: DATA_W];
          cur_q   <= win_idx_i;
          tcnt_q  <= '0;
          st_q    <= ST_REQ;
        end
        ST_REQ: begin
          if (replied) begin
            rdata_q <= bus_rdata_i;
            resp_q  <= bus_ok_i;
            st_q    <= ST_TEAR;
          end else if (bus_ok_i == OK_READY) begin
            if (tcnt_q == TCNT_W'(TIMEOUT - 1)) begin
              rdata_q <= '0;
              resp_q  <= OK_ERR;
              st_q    <= ST_TEAR;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end else begin
            tcnt_q <= '0;
          end
        end
        ST_TEAR: if (bus_ok_i == OK_READY) begin
          done_q[cur_q] <= 1'b1;
          st_q          <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_HOLD_KEEPS_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_op_o != OP_IDLE && bus_ok_i == OK_HOLD) |=> bus_op_o == $past(bus_op_o)); // R2
  AST_DONE_AFTER_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_o) |-> ($past(bus_ok_i) == OK_READY && $past(bus_op_o) == OP_IDLE)); // R2
  AST_ONE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o)); // R3
  AST_NEW_OP_ON_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_op_o != OP_IDLE && $past(bus_op_o) == OP_IDLE) |-> $past(bus_ok_i) == OK_READY); // R3
endmodule

// File: rtl/mmio_dev.sv
module mmio_dev
  import mmio_pkg::*;
#(
  parameter int              DEV_ID   = 0,
  parameter logic [PAGE_W-1:0] PAGE   = 16,
  parameter int              REGS     = 8,
  parameter int              HOLD_CYC = 2,
  localparam int RIDX_W = $clog2(REGS),
  localparam int WCNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   bus_op_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [OK_W-1:0]   ok_o,
  output logic [DATA_W-1:0] rdata_o
);
  typedef enum logic [1:0] {D_IDLE, D_WAIT, D_RESP} dst_e;

  dst_e              st_q;
  logic [WCNT_W-1:0] wcnt_q;
  logic [1:0]        cls_q;
  logic [2:0]        sz_q;
  logic [RIDX_W-1:0] ridx_q;
  logic [DATA_W-1:0] wd_q;
  logic [OK_W-1:0]   code_q;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] mem_q [REGS];

  logic [1:0]        cls_in;
  logic [2:0]        sz_in;
  logic              hit;
  logic              size_ok;
  logic [DATA_W-1:0] old_w;
  logic [DATA_W-1:0] old_ret;
  logic [DATA_W-1:0] new_w;
  logic              unused_addr;

  assign cls_in      = bus_op_i[4:3];
  assign sz_in       = bus_op_i[2:0];
  assign unused_addr = ^{bus_addr_i[OFF_W-1:3+RIDX_W], bus_addr_i[2:0]};
  assign hit = (bus_op_i != OP_IDLE) &&
               ((cls_in == CLS_SPEC) ? (sz_in == SZ_PROBE)
                                     : (bus_addr_i[ADDR_W-1:OFF_W] == PAGE));

  assign size_ok = (sz_q == SZ_DW) || (sz_q == SZ_QW);
  assign old_w   = mem_q[ridx_q];
  assign old_ret = (sz_q == SZ_DW) ? {32'h0, old_w[31:0]} : old_w;
  assign new_w   = (sz_q == SZ_DW) ? {old_w[63:32], wd_q[31:0]} : wd_q;

  always_comb begin
    unique case (st_q)
      D_WAIT:  ok_o = OK_HOLD;
      D_RESP:  ok_o = code_q;
      default: ok_o = OK_READY;
    endcase
  end
  assign rdata_o = (st_q == D_RESP) ? rd_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= D_IDLE;
      wcnt_q <= '0;
      cls_q  <= CLS_SPEC;
      sz_q   <= '0;
      ridx_q <= '0;
      wd_q   <= '0;
      code_q <= OK_READY;
      rd_q   <= '0;
      for (int i = 0; i < REGS; i++) mem_q[i] <= '0;
    end else begin
      unique case (st_q)
        D_IDLE: if (hit) begin
          cls_q  <= cls_in;
          sz_q   <= sz_in;
          ridx_q <= bus_addr_i[3 +: RIDX_W];
          wd_q   <= bus_wdata_i;
          wcnt_q <= WCNT_W'(HOLD_CYC - 1);
          st_q   <= D_WAIT;
        end
        D_WAIT: if (wcnt_q == '0) begin
          st_q <= D_RESP;
          if (cls_q == CLS_SPEC) begin
            code_q <= OK_DONE;
            rd_q   <= DATA_W'(DEV_ID);
          end else if (!size_ok) begin
            code_q <= OK_ERR;
            rd_q   <= '0;
          end else begin
            code_q <= OK_DONE;
            rd_q   <= (cls_q == CLS_STORE) ? '0 : old_ret;
            if (cls_q != CLS_LOAD) mem_q[ridx_q] <= new_w;
          end
        end else begin
          wcnt_q <= wcnt_q - 1'b1;
        end
        D_RESP: if (bus_op_i == OP_IDLE) st_q <= D_IDLE;
        default: st_q <= D_IDLE;
      endcase
    end
  end

  AST_HOLD_BEFORE_REPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_o != OK_READY && ok_o != OK_HOLD && $past(ok_o) == OK_READY) |-> 1'b0); // R5
  AST_RELEASE_ON_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(bus_op_i) == OP_IDLE && $past(ok_o) != OK_HOLD) |-> ok_o == OK_READY); // R2
endmodule

// File: rtl/mmio_reply_mux.sv
module mmio_reply_mux
  import mmio_pkg::*;
#(
  parameter int N_DEV = 3
) (
  input  logic [N_DEV*OK_W-1:0]   dev_ok_i,
  input  logic [N_DEV*DATA_W-1:0] dev_rdata_i,
  output logic [OK_W-1:0]         ok_o,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    collide_o
);
  logic [N_DEV-1:0] active;

  for (genvar d = 0; d < N_DEV; d++) begin : g_act
    assign active[d] = dev_ok_i[d*OK_W +: OK_W] != OK_READY;
  end

  // scan downward so the lowest active device is the last to write
  always_comb begin
    ok_o    = OK_READY;
    rdata_o = '0;
    for (int d = N_DEV - 1; d >= 0; d--) begin
      if (active[d]) begin
        ok_o    = dev_ok_i[d*OK_W +: OK_W];
        rdata_o = dev_rdata_i[d*DATA_W +: DATA_W];
      end
    end
  end

  assign collide_o = $countones(active) > 1;
endmodule

// File: rtl/mmio_bus_top.sv
module mmio_bus_top
  import mmio_pkg::*;
#(
  parameter int N_INIT    = 2,
  parameter int N_DEV     = 3,
  parameter int REGS      = 8,
  parameter int PAGE_BASE = 16,
  parameter int HOLD_CYC  = 2,
  parameter int TIMEOUT   = 16,
  parameter int AGE_W     = 8,
  localparam int IDX_W    = (N_INIT > 1) ? $clog2(N_INIT) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_INIT-1:0]        req_i,
  input  logic [N_INIT*OP_W-1:0]   op_i,
  input  logic [N_INIT*ADDR_W-1:0] addr_i,
  input  logic [N_INIT*DATA_W-1:0] wdata_i,
  output logic [N_INIT-1:0]        done_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [OK_W-1:0]          resp_o,
  output logic [OP_W-1:0]          bus_op_o,
  output logic [ADDR_W-1:0]        bus_addr_o,
  output logic [OK_W-1:0]          bus_ok_o,
  output logic                     collide_o
);
  logic                    win_valid, take, busy;
  logic [IDX_W-1:0]        win_idx, cur_idx;
  logic [N_INIT-1:0]       served, elig;
  logic [DATA_W-1:0]       bus_wdata, bus_rdata;
  logic [N_DEV*OK_W-1:0]   dev_ok;
  logic [N_DEV*DATA_W-1:0] dev_rdata;

  for (genvar i = 0; i < N_INIT; i++) begin : g_srv
    assign served[i] = busy && (cur_idx == IDX_W'(i));
  end
  assign elig = req_i & ~done_o & ~served;

  mmio_arbiter #(.N_INIT(N_INIT), .AGE_W(AGE_W)) u_arb (
    .clk_i, .rst_ni,
    .elig_i      (elig),
    .take_i      (take),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx)
  );

  mmio_master #(.N_INIT(N_INIT), .TIMEOUT(TIMEOUT)) u_mst (
    .clk_i, .rst_ni,
    .win_valid_i (win_valid),
    .win_idx_i   (win_idx),
    .op_i, .addr_i, .wdata_i,
    .bus_ok_i    (bus_ok_o),
    .bus_rdata_i (bus_rdata),
    .take_o      (take),
    .busy_o      (busy),
    .cur_idx_o   (cur_idx),
    .bus_op_o, .bus_addr_o,
    .bus_wdata_o (bus_wdata),
    .done_o, .rdata_o, .resp_o
  );

  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    mmio_dev #(
      .DEV_ID   (d),
      .PAGE     (PAGE_W'(PAGE_BASE + d)),
      .REGS     (REGS),
      .HOLD_CYC (HOLD_CYC)
    ) u_dev (
      .clk_i, .rst_ni,
      .bus_op_i    (bus_op_o),
      .bus_addr_i  (bus_addr_o),
      .bus_wdata_i (bus_wdata),
      .ok_o        (dev_ok[d*OK_W +: OK_W]),
      .rdata_o     (dev_rdata[d*DATA_W +: DATA_W])
    );
  end

  mmio_reply_mux #(.N_DEV(N_DEV)) u_mux (
    .dev_ok_i    (dev_ok),
    .dev_rdata_i (dev_rdata),
    .ok_o        (bus_ok_o),
    .rdata_o     (bus_rdata),
    .collide_o   (collide_o)
  );

  AST_COLLIDE_ON_REPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collide_o |-> bus_ok_o != OK_READY); // R7
  AST_NO_REPLY_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && $past(!busy)) |-> bus_ok_o == OK_READY); // R6
endmodule

// File: tb/mmio_bus_top_tb.sv
`timescale 1ns/1ps
module mmio_bus_top_tb;
  localparam logic [4:0] LD_QW = 5'b01011, LD_DW = 5'b01010, LD_TL = 5'b01111;
  localparam logic [4:0] ST_QW = 5'b10011, ST_DW = 5'b10010, ST_BAD = 5'b10100;
  localparam logic [4:0] SW_QW = 5'b11011, SW_DW = 5'b11010;
  localparam logic [4:0] PROBE = 5'b00001, SPEC2 = 5'b00010;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   req = '0;
  logic [4:0]   s_op [2];
  logic [27:0]  s_addr [2];
  logic [63:0]  s_wd [2];
  logic [1:0]   done;
  logic [63:0]  rdata;
  logic [1:0]   resp, bus_ok;
  logic [4:0]   bus_op;
  logic [27:0]  bus_addr;
  logic         collide;

  always #2.5 clk = ~clk;

  mmio_bus_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .op_i({s_op[1], s_op[0]}), .addr_i({s_addr[1], s_addr[0]}),
    .wdata_i({s_wd[1], s_wd[0]}),
    .done_o(done), .rdata_o(rdata), .resp_o(resp),
    .bus_op_o(bus_op), .bus_addr_o(bus_addr), .bus_ok_o(bus_ok),
    .collide_o(collide)
  );

  int checks = 0, bad = 0, cyc = 0;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  // behavioural model: arrival queue, register image, scheduled transaction
  logic [63:0] mreg [3][8];
  int  q[$];
  bit  inq [2];
  bit  act_on = 0;
  int  a_idx, a_p, a_kind, a_done;
  logic [4:0]  a_op;
  logic [63:0] a_rd;
  logic [1:0]  a_resp;

  task automatic plan_txn(input int i, input int p);
    logic [1:0] cls; logic [2:0] sz; int page, d, k; logic [63:0] old, ret, nw;
    cls = s_op[i][4:3]; sz = s_op[i][2:0]; page = int'(s_addr[i][27:12]);
    k = int'(s_addr[i][5:3]);
    a_idx = i; a_p = p; a_op = s_op[i]; a_rd = '0; a_resp = 2'b01; act_on = 1;
    if (cls == 2'b00) a_kind = (sz == 3'b001) ? 3 : 2;
    else if (page < 16 || page > 18) a_kind = 2;
    else if (sz != 3'b010 && sz != 3'b011) a_kind = 1;
    else begin
      a_kind = 0; d = page - 16; old = mreg[d][k];
      ret = (sz == 3'b010) ? {32'h0, old[31:0]} : old;
      nw  = (sz == 3'b010) ? {old[63:32], s_wd[i][31:0]} : s_wd[i];
      if (cls != 2'b10) a_rd = ret;
      if (cls != 2'b01) mreg[d][k] = nw;
    end
    if (a_kind == 1 || a_kind == 2) a_resp = 2'b11;
    a_done = p + ((a_kind == 2) ? 17 : 6);
  endtask

  string rtag;
  always @(negedge clk) begin
    if (rst_n) begin
      int n; logic [1:0] e_done, e_ok; logic [4:0] e_op; bit e_col;
      n = cyc; e_done = '0; e_op = '0; e_ok = 2'b00; e_col = 0;
      if (act_on) begin
        if (n == a_done) e_done[a_idx] = 1'b1;
        if (n >= a_p && n <= a_p + ((a_kind == 2) ? 15 : 3)) e_op = a_op;
        if (a_kind != 2) begin
          if (n == a_p + 1 || n == a_p + 2) e_ok = 2'b10;
          if (n == a_p + 3 || n == a_p + 4) e_ok = (a_kind == 1) ? 2'b11 : 2'b01;
        end
        e_col = (a_kind == 3) && n >= a_p + 1 && n <= a_p + 4;
      end
      chk(done === e_done, "R10/R2 done", 64'(done), 64'(e_done));
      chk(bus_op === e_op, "R1/R3 bus_op", 64'(bus_op), 64'(e_op));
      chk(bus_ok === e_ok, "R5 bus_ok", 64'(bus_ok), 64'(e_ok));
      chk(collide === e_col, "R7 collide", 64'(collide), 64'(e_col));
      if (act_on && n == a_done) begin
        rtag = (a_kind == 0) ? "R4 rdata" : (a_kind == 1) ? "R9 rdata" :
               (a_kind == 2) ? "R8 rdata" : "R7 rdata";
        chk(rdata === a_rd, rtag, rdata, a_rd);
        chk(resp === a_resp, "R6 resp", 64'(resp), 64'(a_resp));
      end
      for (int i = 0; i < 2; i++) begin
        if (!req[i]) inq[i] = 0;
        else if (!inq[i]) begin q.push_back(i); inq[i] = 1; end
      end
      if (act_on && n >= a_done) act_on = 0;
      if (!act_on && q.size() > 0) plan_txn(q.pop_front(), n + 1);
      if (cyc > 20000) begin
        bad++;
        $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
      end
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask
  function automatic logic [27:0] ad(input int page, input int k);
    return 28'((page << 12) | (k << 3));
  endfunction
  task automatic fire(input int i, input logic [4:0] op, input logic [27:0] a, input logic [63:0] wd);
    s_op[i] = op; s_addr[i] = a; s_wd[i] = wd; req[i] = 1'b1;
  endtask
  task automatic wait_all();
    do begin
      tick();
      for (int i = 0; i < 2; i++) if (done[i]) req[i] = 1'b0;
    end while (|req);
  endtask
  task automatic one(input int i, input logic [4:0] op, input logic [27:0] a, input logic [63:0] wd);
    fire(i, op, a, wd); wait_all(); tick();
  endtask

  initial begin
    for (int d = 0; d < 3; d++) for (int k = 0; k < 8; k++) mreg[d][k] = '0;
    for (int i = 0; i < 2; i++) begin s_op[i] = '0; s_addr[i] = '0; s_wd[i] = '0; inq[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk(bus_op === 5'b0, "R11 reset op", 64'(bus_op), 0);
    chk(bus_ok === 2'b00, "R11 reset ok", 64'(bus_ok), 0);
    chk(done === 2'b00, "R11 reset done", 64'(done), 0);
    chk(collide === 1'b0, "R11 reset collide", 64'(collide), 0);
    @(negedge clk); rst_n = 1'b1;
    tick();
    // R4 64-bit store/load, 32-bit merge, swaps
    one(0, ST_QW, ad(16, 2), 64'h1122_3344_5566_7788);
    one(1, LD_QW, ad(16, 2), '0);
    one(0, ST_QW, ad(17, 5), 64'hAAAA_BBBB_CCCC_DDDD);
    one(0, ST_DW, ad(17, 5), 64'hFFFF_FFFF_0123_4567);
    one(1, LD_QW, ad(17, 5), '0);
    one(1, LD_DW, ad(17, 5), '0);
    one(0, SW_QW, ad(18, 7), 64'h0F0F_0F0F_0F0F_0F0F);
    one(0, SW_QW, ad(18, 7), 64'h1234_0000_0000_9876);
    one(1, SW_DW, ad(18, 7), 64'h5555_5555_DEAD_BEEF);
    one(1, LD_QW, ad(18, 7), '0);
    // R9 unsupported sizes leave registers untouched
    one(0, LD_TL, ad(16, 2), '0);
    one(0, ST_BAD, ad(16, 2), 64'hFFFF);
    one(1, LD_QW, ad(16, 2), '0);
    // R8 unclaimed requests time out
    one(0, LD_QW, ad(3, 1), '0);
    one(1, SPEC2, ad(16, 0), '0);
    // R7 probe answered by all devices
    one(0, PROBE, ad(0, 0), '0);
    // R10 same-cycle arrivals: lower index first
    fire(0, LD_QW, ad(16, 2), '0);
    fire(1, LD_QW, ad(17, 5), '0);
    wait_all(); tick();
    // R10 older waiting request beats a lower index arriving later
    fire(0, ST_QW, ad(16, 1), 64'h1);
    tick(); tick();
    fire(1, ST_QW, ad(16, 1), 64'h2);
    while (!done[0]) tick();
    req[0] = 1'b0;
    tick();
    fire(0, LD_QW, ad(16, 1), '0);
    wait_all(); tick();
    repeat (4) tick();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule